// File: doc/BRIEF.md
# Five-Level Notched Gate Pattern Generator

This block drives the eight gate signals of a single-phase inverter built from two H-bridge cells in series. The two cells together give a five-level staircase voltage. A free-running phase counter covers one output period. Six programmable notch angles are held as count values inside the first quarter of that period. Quarter-wave and half-wave symmetry fold every phase count back onto that quarter, so the same six values define the whole waveform.

Each cell owns three consecutive angles. As the folded phase passes those angles, the cell steps between its active level and zero: on at the first angle, off at the second, on again at the third. This gives three notches per quarter instead of a single staircase step. The active level is positive in the first half period and negative in the second. The cell level is then decoded into its four switch gates and registered.

Software or a host loads the angles through a small write port. Writes go into a holding bank and only take effect when the counter wraps. As a result, no output period ever mixes two angle sets. Angle computation, dead-time and isolated drivers are outside this block.

Top module: `she_gate_gen`

## Requirements
- R1: The phase counter runs from 0 to PERIOD-1 and then returns to 0, so the gate pattern repeats every PERIOD cycles. The default PERIOD is 1,000,000 (a 20 ms period at 50 MHz).
- R2: While rst is high, all eight gate outputs are 0 from the first clock edge onward.
- R3: The folded phase is computed in two steps. For phase p, let q = p mod PERIOD/2. The folded phase is then m = q if q <= PERIOD/4, and m = PERIOD/2 - q otherwise. As a result, an angle a produces a second edge at count PERIOD/2 - a, with the opposite direction.
- R4: Cell c uses angle slots 3c, 3c+1 and 3c+2. That is, slots 0 to 2 belong to cell 0 and slots 3 to 5 belong to cell 1. A cell is active when an odd number of its three angles are less than or equal to m.
- R5: An active cell gives +V when p < PERIOD/2 and -V otherwise. An inactive cell gives zero.
- R6: Each cell has a 4-bit slice of gate_o, at bits [4c+3:4c]. Within a slice, bit0 is the upper-left switch, bit1 the lower-left, bit2 the upper-right and bit3 the lower-right. The codes are +V = 4'b1001, -V = 4'b0110 and zero = 4'b1010 (both lower switches on).
- R7: In no cycle are both switches of one leg on at once. For each cell, this means bit0 with bit1, and bit2 with bit3.
- R8: A write with ang_wr_en stores ang_wr_data in holding slot ang_wr_idx. A write to an index of 6 or more is ignored. The holding bank is copied to the working angles only on the cycle in which the counter wraps. Both banks reset to 0.
- R9: The reference set uses the angles 39.96, 45.26, 50.29, 72.56, 77.67 and 84.67 degrees. Each angle is converted to counts as round(angle × PERIOD / 360). With PERIOD = 3600, this gives switching edges at counts 400, 453, 503, 726, 777 and 847. The mirror images of these edges fall in the second quarter.
- R10: The sum of the two cell levels takes all five values -2, -1, 0, +1 and +2 over one period of the reference set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ang_wr_en | input | 1 | Angle write strobe |
| ang_wr_idx | input | IW (3) | Holding slot index, 0 to 5 |
| ang_wr_data | input | CW (20) | Angle in counts |
| gate_o | output | 4*NCELLS (8) | Registered gate drives, one 4-bit slice per cell |

## Verification
The bench uses the reference angle set and probes the counts just before and just at each edge. It also probes the mirrored edges in the second quarter and the negative half. An off-by-one comparison or a wrong fold would move an edge by one count, and one of these probes would catch it. A second angle set is written in the middle of a period. Logic that applied it at once, instead of at the wrap, would show the new notches too early. A write to slot 7 must leave the pattern untouched. A swapped zero-state or a swapped diagonal would produce illegal codes or a shorted leg, which the bench also checks.

// File: rtl/she_pkg.sv
package she_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'd0,
    LVL_POS  = 2'd1,
    LVL_NEG  = 2'd2
  } cell_level_e;

  // slice bits: 0 upper-left, 1 lower-left, 2 upper-right, 3 lower-right
  localparam logic [3:0] GATE_OFF  = 4'b0000;
  localparam logic [3:0] GATE_POS  = 4'b1001;
  localparam logic [3:0] GATE_NEG  = 4'b0110;
  localparam logic [3:0] GATE_ZERO = 4'b1010;

  function automatic logic [3:0] level_to_gate(input cell_level_e lvl);
    case (lvl)
      LVL_POS: return GATE_POS;
      LVL_NEG: return GATE_NEG;
      default: return GATE_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/she_phase_ctr.sv
module she_phase_ctr #(
  parameter int PERIOD = 1000000,
  parameter int CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          wrap_o,
  output logic [CW-1:0] fold_o,
  output logic          neg_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);
  localparam logic [CW-1:0] QTR  = CW'(PERIOD / 4);

  logic [CW-1:0] cnt;
  logic [CW-1:0] in_half;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    wrap_o  = (cnt == LAST);
    neg_o   = (cnt >= HALF);
    in_half = neg_o ? (cnt - HALF) : cnt;
    fold_o  = (in_half <= QTR) ? in_half : (HALF - in_half);
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
  // R3
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    (fold_o <= QTR));

endmodule

// File: rtl/she_angle_bank.sv
module she_angle_bank #(
  parameter int NANG = 6,
  parameter int CW   = 20,
  parameter int IW   = $clog2(NANG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [CW-1:0]            wr_data,
  input  logic                     wrap,
  output logic [NANG-1:0][CW-1:0]  act_o
);
  logic [NANG-1:0][CW-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      act_o  <= '0;
    end else begin
      if (wr_en && (int'(wr_idx) < NANG)) shadow[wr_idx] <= wr_data;
      if (wrap) act_o <= shadow;
    end
  end

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_o));
  // R8
  act_load_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (act_o == $past(shadow)));

endmodule

// File: rtl/she_cell_level.sv
module she_cell_level
  import she_pkg::*;
#(
  parameter int NOTCH = 3,
  parameter int CW    = 20
) (
  input  logic [CW-1:0]             fold_i,
  input  logic                      neg_i,
  input  logic [NOTCH-1:0][CW-1:0]  ang_i,
  output cell_level_e               lvl_o
);
  logic [NOTCH-1:0] crossed;

  for (genvar i = 0; i < NOTCH; i++) begin : g_cmp
    assign crossed[i] = (fold_i >= ang_i[i]);
  end

  always_comb begin
    if (^crossed) lvl_o = neg_i ? LVL_NEG : LVL_POS;
    else          lvl_o = LVL_ZERO;
  end

endmodule

// File: rtl/she_gate_gen.sv
module she_gate_gen
  import she_pkg::*;
#(
  parameter int PERIOD = 1000000,
  parameter int NCELLS = 2,
  parameter int NOTCH  = 3,
  parameter int CW     = $clog2(PERIOD),
  parameter int IW     = $clog2(NCELLS * NOTCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ang_wr_en,
  input  logic [IW-1:0]         ang_wr_idx,
  input  logic [CW-1:0]         ang_wr_data,
  output logic [4*NCELLS-1:0]   gate_o
);
  localparam int NANG = NCELLS * NOTCH;

  logic                    wrap;
  logic                    neg;
  logic [CW-1:0]           fold;
  logic [NANG-1:0][CW-1:0] act;

  she_phase_ctr #(.PERIOD(PERIOD), .CW(CW)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .wrap_o (wrap),
    .fold_o (fold),
    .neg_o  (neg)
  );

  she_angle_bank #(.NANG(NANG), .CW(CW), .IW(IW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ang_wr_en),
    .wr_idx  (ang_wr_idx),
    .wr_data (ang_wr_data),
    .wrap    (wrap),
    .act_o   (act)
  );

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    cell_level_e lvl;
    logic [3:0]  gq;

    she_cell_level #(.NOTCH(NOTCH), .CW(CW)) u_lvl (
      .fold_i (fold),
      .neg_i  (neg),
      .ang_i  (act[c*NOTCH +: NOTCH]),
      .lvl_o  (lvl)
    );

    always_ff @(posedge clk) begin
      if (rst) gq <= GATE_OFF;
      else     gq <= level_to_gate(lvl);
    end

    assign gate_o[4*c +: 4] = gq;

    // R7
    leg_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(gq[0] && gq[1]) && !(gq[2] && gq[3]));
    // R2
    rst_off_chk: assert property (@(posedge clk)
      rst |=> (gq == GATE_OFF));
    // R6
    gate_code_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (gq == GATE_POS || gq == GATE_NEG || gq == GATE_ZERO));
  end

endmodule

// File: tb/she_gate_gen_bench.sv
module she_gate_gen_bench;
  localparam int P  = 3600;
  localparam int CW = $clog2(P);
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ang_wr_en = 1'b0;
  logic [IW-1:0] ang_wr_idx = '0;
  logic [CW-1:0] ang_wr_data = '0;
  logic [7:0]    gate_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  she_gate_gen #(.PERIOD(P), .NCELLS(2), .NOTCH(3), .CW(CW), .IW(IW)) u_she_gate_gen (
    .clk         (clk),
    .rst         (rst),
    .ang_wr_en   (ang_wr_en),
    .ang_wr_idx  (ang_wr_idx),
    .ang_wr_data (ang_wr_data),
    .gate_o      (gate_o)
  );

  int sh [6];
  int ac [6];
  int k = 0;
  logic [31:0] sbq [$];
  logic [7:0] seen1 [P];
  logic [7:0] seen2 [P];
  bit sum_seen [5];

  function automatic logic [7:0] model(input int ph, input int a [6]);
    logic [7:0] r;
    int q, m, n;
    bit neg;
    neg = (ph >= P/2);
    q = neg ? ph - P/2 : ph;
    m = (q <= P/4) ? q : P/2 - q;
    for (int c = 0; c < 2; c++) begin
      n = 0;
      for (int j = 0; j < 3; j++) if (m >= a[c*3+j]) n++;
      r[4*c +: 4] = (n % 2 == 1) ? (neg ? 4'b0110 : 4'b1001) : 4'b1010;
    end
    return r;
  endfunction

  function automatic int lvl_of(input logic [3:0] g);
    if (g == 4'b1001) return 1;
    if (g == 4'b0110) return -1;
    return 0;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // predictor: pushes the expected gate word for each edge
  always @(posedge clk) begin
    int ph;
    if (rst) begin
      k = 0;
      sbq.push_back({8'hFF, 16'd0, 8'h00});
    end else begin
      ph = k % P;
      if (ph == 0) ac = sh;
      sbq.push_back({8'(k / P), 16'(ph), model(ph, ac)});
      k++;
    end
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    logic [31:0] it;
    int per, ph;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      per = int'(it[31:24]);
      ph  = int'(it[23:8]);
      check(gate_o, it[7:0], "R1 R3 R4 R5 R6 R2 scoreboard");
      // R7
      if ((gate_o[0] && gate_o[1]) || (gate_o[2] && gate_o[3]) ||
          (gate_o[4] && gate_o[5]) || (gate_o[6] && gate_o[7])) begin
        tests++; fails++;
        $display("FAIL R7 leg short actual=%b expected=no leg pair on", gate_o);
      end
      if (per == 1) begin
        seen1[ph] = gate_o;
        sum_seen[lvl_of(gate_o[3:0]) + lvl_of(gate_o[7:4]) + 2] = 1'b1;
      end
      if (per == 2) seen2[ph] = gate_o;
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    ang_wr_en   = 1'b1;
    ang_wr_idx  = IW'(idx);
    ang_wr_data = CW'(val);
    if (idx < 6) sh[idx] = val;
    @(negedge clk);
    ang_wr_en = 1'b0;
  endtask

  function automatic int deg_to_cnt(input int hundredths);
    return (hundredths * P + 18000) / 36000;
  endfunction

  initial begin
    int ref_hd [6];
    ref_hd = '{3996, 4526, 5029, 7256, 7767, 8467};
    for (int i = 0; i < 6; i++) begin sh[i] = 0; ac[i] = 0; end
    fork
      begin
        repeat (4) @(negedge clk);
        check(gate_o, 8'h00, "R2 reset off");
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 6; i++) wr(i, deg_to_cnt(ref_hd[i]));
        wr(7, 5);  // R8 out-of-range slot ignored
        wait (k == P + 1000);
        @(negedge clk);
        wr(0, 100); wr(1, 200); wr(2, 300);
        wr(3, 600); wr(4, 700); wr(5, 800);
        wait (k == 3*P + 5);
        @(negedge clk);
        // R9 edge positions of the reference set
        check({4'h0, seen1[399][3:0]}, 8'h0A, "R9 cell0 before 400");
        check({4'h0, seen1[400][3:0]}, 8'h09, "R9 cell0 at 400");
        check({4'h0, seen1[452][3:0]}, 8'h09, "R9 cell0 before 453");
        check({4'h0, seen1[453][3:0]}, 8'h0A, "R9 cell0 at 453");
        check({4'h0, seen1[502][3:0]}, 8'h0A, "R9 cell0 before 503");
        check({4'h0, seen1[503][3:0]}, 8'h09, "R9 cell0 at 503");
        check({4'h0, seen1[725][7:4]}, 8'h0A, "R9 cell1 before 726");
        check({4'h0, seen1[726][7:4]}, 8'h09, "R9 cell1 at 726");
        check({4'h0, seen1[777][7:4]}, 8'h0A, "R9 cell1 at 777");
        check({4'h0, seen1[847][7:4]}, 8'h09, "R9 cell1 at 847");
        // R3 mirror edges
        check({4'h0, seen1[1400][3:0]}, 8'h09, "R3 mirror of 400 still on");
        check({4'h0, seen1[1401][3:0]}, 8'h0A, "R3 mirror of 400 off");
        check({4'h0, seen1[1347][3:0]}, 8'h0A, "R3 mirror of 453");
        // R5 negative half
        check({4'h0, seen1[2200][3:0]}, 8'h06, "R5 negative half cell0");
        check(seen1[2700], 8'h66, "R5 negative peak both cells");
        check(seen1[900], 8'h99, "R4 positive peak both cells");
        // R8 new set only after wrap
        check({4'h0, seen1[1899][3:0]}, 8'h0A, "R8 mid-period write deferred");
        check({4'h0, seen2[150][3:0]}, 8'h09, "R8 new set active next period");
        check({4'h0, seen2[250][3:0]}, 8'h0A, "R8 new set notch");
        // R10 all five levels
        for (int s = 0; s < 5; s++)
          check({7'd0, sum_seen[s]}, 8'h01, $sformatf("R10 level %0d present", s - 2));
        // R2 reset re-asserted mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(gate_o, 8'h00, "R2 reset mid-run");
        repeat (2) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule